// File: doc/BRIEF.md
# Dual Regulator Enable Sequencer

This block is the digital control for a pair of regulator channels that each have their own enable input. When either enable is raised, it waits for the supply monitor to report that the input rail is above its rising threshold. It then steps through the shared bring-up stages: trim capture, bandgap, reference and bias generation, and bypass-node fast charge. Each stage gets a single-cycle start strobe, and the block waits for that stage's done handshake before moving on. Once the last stage completes, it hands out per-channel ramp enables to the soft-start generators.

Channel 1 has priority. Channel 2 is held back whenever channel 1 is enabled but has not yet reached its target. The exception is when channel 2 has already begun ramping: in that case channel 1 is started straight away, alongside it.

A falling-threshold trip from the supply monitor removes both ramp enables and restarts the whole sequence once the rail recovers. Dropping both enables returns the block to shutdown.

Top module: `dual_rail_sequencer`

## Requirements
- R1: While reset is asserted, and while both enables are low, every stage start strobe and both ramp enables are low.
- R2: After an enable rises, no stage strobe is issued until supplyRiseOk is sampled high. The trim strobe (stageStart bit 0) appears on the edge that samples supplyRiseOk high in the waiting state, one edge after the enable was first sampled.
- R3: Stage strobes follow the fixed order bit 0 trim, bit 1 bandgap, bit 2 reference/bias, bit 3 bypass charge. Each strobe is a one-cycle pulse and at most one is high at a time. Strobe k+1 rises on the edge that samples stageDone bit k high.
- R4: No ramp enable is high before the bypass stage's done bit is sampled. Channel 1's ramp enable (chRampEn bit 0) rises on the second edge after that sample.
- R5: When both enables are high as the channels start, channel 1 ramps first. Channel 2 (chRampEn bit 1) rises on the second edge after chAtTarget bit 0 is sampled high.
- R6: If channel 2 is enabled while channel 1 is ramping but has not reached its target, channel 2 waits for channel 1's target as in R5.
- R7: If channel 2 is enabled first and channel 1 is enabled during the bring-up stages, channel 1 ramps first and channel 2 waits for it as in R5.
- R8: If channel 1 is enabled while channel 2 is already ramping, channel 1's ramp enable rises on the next edge and channel 2 stays on.
- R9: A supplyFallTrip sampled during the stages or the channel phase clears both ramp enables on the next edge and stops the stage strobes. The trim strobe is issued again once supplyRiseOk is sampled high.
- R10: Lowering one channel's enable clears that channel's ramp enable on the next edge and leaves the other channel's ramp enable unchanged.
- R11: Lowering both enables returns the block to shutdown. The next enable reruns the whole sequence from the supply check and the trim stage.
- R12: Channel 2 enabled alone ramps on the second edge after the bypass done bit is sampled, without waiting on channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chEnable | input | 2 | Channel enables, bit 0 channel 1, bit 1 channel 2 |
| supplyRiseOk | input | 1 | Supply above rising threshold |
| supplyFallTrip | input | 1 | Supply below falling threshold |
| stageDone | input | 4 | Per-stage done handshake, same bit order as stageStart |
| chAtTarget | input | 2 | Channel output reached its target level |
| stageStart | output | 4 | One-cycle stage start strobes |
| chRampEn | output | 2 | Per-channel ramp enable to the soft-start generators |

## Verification
The assertions watch the invariants on every cycle: strobes are one-hot and follow the previous done bit, ramp enables appear only in the channel phase, a supply trip or a dropped enable removes the ramp the next cycle, channel 2 never rises beside an unsettled channel 1, and an eligible channel 1 starts at once. Other behaviours depend on the history of the enables and can only be shown by the bench's scenarios. These are the three arrival orders of the two enables, the restart of the whole sequence after a trip or a full shutdown, and the exact edge at which each strobe and ramp enable appears.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int unsigned STAGE_CNT   = 4;
  localparam int unsigned CH_CNT      = 2;
  localparam int unsigned STAGE_IDX_W = (STAGE_CNT > 1) ? $clog2(STAGE_CNT) : 1;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_SUPPLY,
    ST_STAGE,
    ST_RUN
  } seqStateT;

  typedef struct packed {
    logic [STAGE_CNT-1:0] stageGo;
    logic [CH_CNT-1:0]    launch;
    logic [CH_CNT-1:0]    halt;
    logic                 killAll;
  } seqCmdT;
endpackage

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CH_CNT-1:0]    chEnable,
  input  logic                 supplyRiseOk,
  input  logic                 supplyFallTrip,
  input  logic [STAGE_CNT-1:0] stageDone,
  input  logic [CH_CNT-1:0]    rampEn,
  input  logic [CH_CNT-1:0]    reached,
  output seqCmdT               cmd
);
  localparam logic [STAGE_IDX_W-1:0] LAST_IDX = STAGE_IDX_W'(STAGE_CNT - 1);

  seqStateT               state, nextState;
  logic [STAGE_IDX_W-1:0] idx, nextIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      idx   <= '0;
    end else begin
      state <= nextState;
      idx   <= nextIdx;
    end
  end

  always_comb begin
    nextState = state;
    nextIdx   = idx;
    cmd       = '0;
    if (chEnable == '0) begin
      nextState   = ST_OFF;
      cmd.killAll = (state != ST_OFF);
    end else if (supplyFallTrip && (state == ST_STAGE || state == ST_RUN)) begin
      nextState   = ST_SUPPLY;
      cmd.killAll = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: nextState = ST_SUPPLY;
        ST_SUPPLY: begin
          if (supplyRiseOk) begin
            cmd.stageGo[0] = 1'b1;
            nextIdx        = '0;
            nextState      = ST_STAGE;
          end
        end
        ST_STAGE: begin
          if (stageDone[idx]) begin
            if (idx == LAST_IDX) begin
              nextState = ST_RUN;
            end else begin
              nextIdx              = idx + 1'b1;
              cmd.stageGo[nextIdx] = 1'b1;
            end
          end
        end
        ST_RUN: begin
          cmd.launch[0] = chEnable[0] & ~rampEn[0];
          cmd.launch[1] = chEnable[1] & ~rampEn[1] & (~chEnable[0] | reached[0]);
          cmd.halt      = rampEn & ~chEnable;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  // Ramps only exist in the channel phase (R4)
  p_ramp_only_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> (rampEn == '0));

  // A falling supply trip removes both ramps next cycle (R9)
  p_trip_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (supplyFallTrip && state == ST_RUN) |=> (rampEn == '0));

  // An eligible channel 1 starts without delay (R8)
  p_ch1_prompt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !supplyFallTrip && chEnable[0] && !rampEn[0]) |=> rampEn[0]);

  // A dropped enable removes that channel's ramp next cycle (R10)
  for (genvar i = 0; i < CH_CNT; i++) begin : g_drop
    p_drop_kills_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rampEn[i] && !chEnable[i]) |=> !rampEn[i]);
  end
endmodule

// File: rtl/drs_path.sv
module drs_path
  import drs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqCmdT               cmd,
  input  logic [CH_CNT-1:0]    chAtTarget,
  output logic [STAGE_CNT-1:0] stageStart,
  output logic [CH_CNT-1:0]    rampEn,
  output logic [CH_CNT-1:0]    reached
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stageStart <= '0;
    else        stageStart <= cmd.stageGo;
  end

  for (genvar i = 0; i < CH_CNT; i++) begin : g_ch
    logic rampQ, reachedQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rampQ    <= 1'b0;
        reachedQ <= 1'b0;
      end else if (cmd.killAll || cmd.halt[i]) begin
        rampQ    <= 1'b0;
        reachedQ <= 1'b0;
      end else begin
        if (cmd.launch[i]) rampQ <= 1'b1;
        if (rampQ && chAtTarget[i]) reachedQ <= 1'b1;
      end
    end
    assign rampEn[i]  = rampQ;
    assign reached[i] = reachedQ;
  end

  // Channel 2 never starts beside an unsettled channel 1 (R5)
  p_ch2_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rampEn[1]) && rampEn[0]) |-> $past(reached[0]));
endmodule

// File: rtl/dual_rail_sequencer.sv
module dual_rail_sequencer
  import drs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CH_CNT-1:0]    chEnable,
  input  logic                 supplyRiseOk,
  input  logic                 supplyFallTrip,
  input  logic [STAGE_CNT-1:0] stageDone,
  input  logic [CH_CNT-1:0]    chAtTarget,
  output logic [STAGE_CNT-1:0] stageStart,
  output logic [CH_CNT-1:0]    chRampEn
);
  seqCmdT            cmd;
  logic [CH_CNT-1:0] reached;

  drs_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .chEnable       (chEnable),
    .supplyRiseOk   (supplyRiseOk),
    .supplyFallTrip (supplyFallTrip),
    .stageDone      (stageDone),
    .rampEn         (chRampEn),
    .reached        (reached),
    .cmd            (cmd)
  );

  drs_path u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .chAtTarget (chAtTarget),
    .stageStart (stageStart),
    .rampEn     (chRampEn),
    .reached    (reached)
  );

  // At most one stage strobe at a time (R3)
  p_stage_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stageStart));

  // Trim strobe only after the supply was seen good (R2)
  p_trim_after_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stageStart[0] |-> $past(supplyRiseOk));

  // Each later strobe follows the previous stage's done (R3)
  for (genvar k = 1; k < STAGE_CNT; k++) begin : g_order
    p_stage_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stageStart[k] |-> $past(stageDone[k-1]));
  end
endmodule

// File: tb/dual_rail_sequencer_tb.sv
module dual_rail_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;
  localparam int VEC_N      = 17;

  // [15:14] enable, [13] riseOk, [12] fallTrip, [11:8] done, [7:6] atTarget,
  // [5:2] expected strobes, [1:0] expected ramp enables
  localparam logic [15:0] VEC [VEC_N] = '{
    16'b11_0_0_0000_00_0000_00,
    16'b11_0_0_0000_00_0000_00,
    16'b11_1_0_0000_00_0001_00,
    16'b11_1_0_0000_00_0000_00,
    16'b11_1_0_0001_00_0010_00,
    16'b11_1_0_0010_00_0100_00,
    16'b11_1_0_0000_00_0000_00,
    16'b11_1_0_0100_00_1000_00,
    16'b11_1_0_1000_00_0000_00,
    16'b11_1_0_0000_00_0000_01,
    16'b11_1_0_0000_00_0000_01,
    16'b11_1_0_0000_01_0000_01,
    16'b11_1_0_0000_01_0000_11,
    16'b11_1_0_0000_11_0000_11,
    16'b11_0_1_0000_11_0000_00,
    16'b11_0_1_0000_00_0000_00,
    16'b11_1_0_0000_00_0001_00
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chEnable = '0;
  logic       supplyRiseOk = 1'b0;
  logic       supplyFallTrip = 1'b0;
  logic [3:0] stageDone = '0;
  logic [1:0] chAtTarget = '0;
  logic [3:0] stageStart;
  logic [1:0] chRampEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rail_sequencer u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .chEnable       (chEnable),
    .supplyRiseOk   (supplyRiseOk),
    .supplyFallTrip (supplyFallTrip),
    .stageDone      (stageDone),
    .chAtTarget     (chAtTarget),
    .stageStart     (stageStart),
    .chRampEn       (chRampEn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic [3:0] expS, input logic [1:0] expR, input string req);
    checks++;
    if (stageStart !== expS || chRampEn !== expR) begin
      errors++;
      $display("FAIL %s: actual strobes=%b ramps=%b expected strobes=%b ramps=%b",
               req, stageStart, chRampEn, expS, expR);
    end
  endtask

  task automatic cyc(input logic [1:0] en, input logic rise, input logic trip,
                     input logic [3:0] done, input logic [1:0] tgt,
                     input logic [3:0] expS, input logic [1:0] expR, input string req);
    chEnable       = en;
    supplyRiseOk   = rise;
    supplyFallTrip = trip;
    stageDone      = done;
    chAtTarget     = tgt;
    @(posedge clk);
    @(negedge clk);
    check(expS, expR, req);
  endtask

  task automatic finishStages(input logic [1:0] en, input string req);
    cyc(en, 1'b1, 1'b0, 4'b0001, 2'b00, 4'b0010, 2'b00, req);
    cyc(en, 1'b1, 1'b0, 4'b0010, 2'b00, 4'b0100, 2'b00, req);
    cyc(en, 1'b1, 1'b0, 4'b0100, 2'b00, 4'b1000, 2'b00, req);
    cyc(en, 1'b1, 1'b0, 4'b1000, 2'b00, 4'b0000, 2'b00, req);
  endtask

  function automatic string rowTag(input int i);
    return (i < 3) ? "R2" : (i < 9) ? "R3" : (i == 9) ? "R4" : (i < 14) ? "R5" : "R9";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(4'b0000, 2'b00, "R1 in reset");
    rst_n = 1'b1;
    cyc(2'b00, 1'b1, 1'b0, 4'b1111, 2'b11, 4'b0000, 2'b00, "R1 idle enables low");

    for (int i = 0; i < VEC_N; i++) begin
      logic [15:0] v;
      v = VEC[i];
      cyc(v[15:14], v[13], v[12], v[11:8], v[7:6], v[5:2], v[1:0], rowTag(i));
    end

    // R11: full shutdown
    cyc(2'b00, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R11 shutdown");

    // R7: channel 2 first, channel 1 joins during the stages
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R7 supply check");
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b00, "R7 trim");
    cyc(2'b10, 1'b1, 1'b0, 4'b0001, 2'b00, 4'b0010, 2'b00, "R7 bandgap");
    cyc(2'b11, 1'b1, 1'b0, 4'b0010, 2'b00, 4'b0100, 2'b00, "R7 reference");
    cyc(2'b11, 1'b1, 1'b0, 4'b0100, 2'b00, 4'b1000, 2'b00, "R7 bypass");
    cyc(2'b11, 1'b1, 1'b0, 4'b1000, 2'b00, 4'b0000, 2'b00, "R7 channel phase");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b01, "R7 channel 1 first");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b01, "R7 channel 2 waits");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b01, 4'b0000, 2'b01, "R7 target seen");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b01, 4'b0000, 2'b11, "R7 channel 2 starts");

    // R10: drop channel 1 only
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b11, 4'b0000, 2'b10, "R10 channel 1 off");
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b10, 4'b0000, 2'b10, "R10 channel 2 kept");

    // R8: channel 1 enabled while channel 2 ramps
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b10, 4'b0000, 2'b11, "R8 channel 1 immediate");

    // R11: shutdown and rerun from supply check
    cyc(2'b00, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R11 shutdown again");
    cyc(2'b00, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R1 idle with supply good");
    cyc(2'b01, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R11 supply check again");
    cyc(2'b01, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b00, "R11 trim rerun");
    finishStages(2'b01, "R3 stages");
    cyc(2'b01, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b01, "R4 channel 1 alone");

    // R6: channel 2 enabled before channel 1 settles
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b01, "R6 channel 2 waits");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b01, "R6 still waiting");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b01, 4'b0000, 2'b01, "R6 target seen");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b01, 4'b0000, 2'b11, "R6 channel 2 starts");

    // R12: channel 2 alone
    cyc(2'b00, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R11 shutdown third");
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R12 supply check");
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b00, "R12 trim");
    finishStages(2'b10, "R12 stages");
    cyc(2'b10, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b10, "R12 channel 2 no wait");

    // R9: trip during the stages
    cyc(2'b00, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R11 shutdown fourth");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R9 supply check");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b00, "R9 trim");
    cyc(2'b11, 1'b1, 1'b0, 4'b0001, 2'b00, 4'b0010, 2'b00, "R9 bandgap");
    cyc(2'b11, 1'b0, 1'b1, 4'b0010, 2'b00, 4'b0000, 2'b00, "R9 trip aborts stages");
    cyc(2'b11, 1'b0, 1'b0, 4'b0000, 2'b00, 4'b0000, 2'b00, "R2 waits for supply");
    cyc(2'b11, 1'b1, 1'b0, 4'b0000, 2'b00, 4'b0001, 2'b00, "R9 restart at trim");

    // R1: reset in the middle of a sequence
    rst_n = 1'b0;
    #1;
    check(4'b0000, 2'b00, "R1 reset mid sequence");
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule